// File: doc/BRIEF.md
# Raster-Position Timer Interrupt Controller

This block derives two CPU interrupts from the video raster position. A horizontal and a vertical counter come in as inputs. From them the block raises a vertical-blank NMI and a timer IRQ. The timer IRQ fires at a horizontal position, at the start of a chosen line, or at an exact horizontal and vertical point.

Software programs the block through a small byte-wide write port. That port holds a control byte and two 9-bit targets, each written as a low byte and a high byte. Software then polls or acknowledges through two readable status bytes. Each status byte carries a sticky flag in its top bit, and reading that byte clears the flag.

Region and interlace inputs set the last line of the frame. A target past the last horizontal or vertical position therefore never fires.

Top module: `rastirq_top`

## Requirements
- R1: After a synchronous reset:
    - the control byte reads as zero in its effect: `nmi` and `irq` are low and `autord_en` is low;
    - both flags are clear;
    - both targets hold 0x1FF. Writing only the low byte 0x50 of the horizontal target therefore yields a target of 0x150.
- R2: The write addresses are:
    - 0: control. Bit 7 enables the NMI, bits 5:4 select the timer mode, and bit 0 drives `autord_en`.
    - 1: horizontal target low byte.
    - 2: horizontal target bit 8, taken from data bit 0.
    - 3: vertical target low byte.
    - 4: vertical target bit 8, taken from data bit 0.
- R3: The timer mode selects the match condition:
    - 00: no match.
    - 01: `hcount` equals the horizontal target.
    - 10: `vcount` equals the vertical target and `hcount` is 0.
    - 11: both counts equal their targets.
- R4: A horizontal target above 339 never matches.
- R5: The last line is 261 when `pal_mode`=0 and 311 when `pal_mode`=1. The last line is one higher when `interlace` and `odd_field` are both 1. A vertical target above the last line never matches.
- R6: The timer flag is bit 7 of status byte 1 (`rd_sel`=1). It sets on the cycle after the match condition goes from false to true. A condition that stays true does not set it again.
- R7: A cycle with `rd_en`=1 clears the flag of the status byte selected by `rd_sel`. A set in the same cycle takes priority over the clear.
- R8: The vblank flag is bit 7 of status byte 0. Its bits 3:0 return the parameter `VERSION`. The vblank lines run from `VBL_START_NTSC` (225) or `VBL_START_PAL` (240) up to the last line. The flag sets one cycle after `vcount` enters that range and clears one cycle after it leaves.
- R9: `irq` is high exactly while the timer flag is set and the mode is not 00.
- R10: `nmi` is a one-cycle pulse, issued in the cycle the vblank flag sets, when control bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Status read strobe (clears the selected flag) |
| rd_sel | input | 1 | Status byte select: 0 vblank, 1 timer |
| rd_data | output | 8 | Selected status byte |
| hcount | input | 9 | Horizontal raster position |
| vcount | input | 9 | Vertical raster position |
| pal_mode | input | 1 | Selects the 311-line frame |
| interlace | input | 1 | Interlace enabled |
| odd_field | input | 1 | Current field carries the extra line |
| autord_en | output | 1 | Control bit 0 |
| irq | output | 1 | Timer interrupt request |
| nmi | output | 1 | Vblank NMI pulse |

## Verification
The bench builds the block with its default parameters: a horizontal limit of 339, last lines of 261 and 311, and vblank starting on line 225 or 240. With these values every region and interlace combination can be reached by driving the counters directly. The bench presents exact boundary positions such as 339/340, 261/262 and 311/312, on both even and odd interlaced fields. Because the counter inputs jump freely, each match edge, the read-versus-set collision and the vblank entry and exit can each be produced in a single cycle.

// File: rtl/rastirq_pkg.sv
package rastirq_pkg;

    localparam int CNT_W = 9;
    localparam logic [CNT_W-1:0] TGT_RESET = '1;

    typedef enum logic [1:0] {
        TM_OFF   = 2'b00,
        TM_HONLY = 2'b01,
        TM_VLINE = 2'b10,
        TM_VH    = 2'b11
    } tmode_e;

    typedef struct packed {
        logic   nmi_en;
        tmode_e mode;
        logic   autord_en;
    } ctrl_t;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_HLO  = 3'd1,
        RA_HHI  = 3'd2,
        RA_VLO  = 3'd3,
        RA_VHI  = 3'd4
    } waddr_e;

    typedef struct packed {
        logic [CNT_W-1:0] h;
        logic [CNT_W-1:0] v;
    } target_t;

    function automatic ctrl_t decode_ctrl(input logic [7:0] b);
        ctrl_t c;
        c.nmi_en    = b[7];
        c.mode      = tmode_e'(b[5:4]);
        c.autord_en = b[0];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] last_line(
        input logic [CNT_W-1:0] ntsc_max,
        input logic [CNT_W-1:0] pal_max,
        input logic             pal,
        input logic             extra);
        logic [CNT_W-1:0] base;
        base = pal ? pal_max : ntsc_max;
        return base + {{(CNT_W-1){1'b0}}, extra};
    endfunction

endpackage

// File: rtl/rastirq_regs.sv
module rastirq_regs
    import rastirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output ctrl_t      ctrl,
    output target_t    tgt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            tgt.h <= TGT_RESET;
            tgt.v <= TGT_RESET;
        end else if (wr_en) begin
            case (waddr_e'(wr_addr))
                RA_CTRL: ctrl       <= decode_ctrl(wr_data);
                RA_HLO:  tgt.h[7:0] <= wr_data;
                RA_HHI:  tgt.h[8]   <= wr_data[0];
                RA_VLO:  tgt.v[7:0] <= wr_data;
                RA_VHI:  tgt.v[8]   <= wr_data[0];
                default: ;
            endcase
        end
    end

    // R1: reset returns control and targets to their initial values
    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (ctrl == '0 && tgt.h == TGT_RESET && tgt.v == TGT_RESET));

    // R2: a control write leaves both targets untouched
    a_r2_ctrl_keeps_tgt: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd0) |=> $stable(tgt));

endmodule

// File: rtl/rastirq_match.sv
module rastirq_match
    import rastirq_pkg::*;
#(
    parameter int H_MAX          = 339,
    parameter int V_MAX_NTSC     = 261,
    parameter int V_MAX_PAL      = 311,
    parameter int VBL_START_NTSC = 225,
    parameter int VBL_START_PAL  = 240
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] hcount,
    input  logic [CNT_W-1:0] vcount,
    input  logic             pal_mode,
    input  logic             interlace,
    input  logic             odd_field,
    input  tmode_e           mode,
    input  target_t          tgt,
    output logic             tcond,
    output logic             in_vbl
);

    localparam logic [CNT_W-1:0] HLIM   = CNT_W'(H_MAX);
    localparam logic [CNT_W-1:0] VN_LIM = CNT_W'(V_MAX_NTSC);
    localparam logic [CNT_W-1:0] VP_LIM = CNT_W'(V_MAX_PAL);
    localparam logic [CNT_W-1:0] VBN    = CNT_W'(VBL_START_NTSC);
    localparam logic [CNT_W-1:0] VBP    = CNT_W'(VBL_START_PAL);

    logic [CNT_W-1:0] vmax;
    logic [CNT_W-1:0] vbl_first;
    logic             h_ok;
    logic             v_ok;
    logic             h_hit;
    logic             v_hit;
    logic             h_zero;

    always_comb begin
        vmax      = last_line(VN_LIM, VP_LIM, pal_mode, interlace && odd_field);
        vbl_first = pal_mode ? VBP : VBN;
        h_ok      = (tgt.h <= HLIM);
        v_ok      = (tgt.v <= vmax);
        h_hit     = h_ok && (hcount == tgt.h);
        v_hit     = v_ok && (vcount == tgt.v);
        h_zero    = (hcount == '0);
        in_vbl    = (vcount >= vbl_first) && (vcount <= vmax);
        unique case (mode)
            TM_OFF:   tcond = 1'b0;
            TM_HONLY: tcond = h_hit;
            TM_VLINE: tcond = v_hit && h_zero;
            TM_VH:    tcond = v_hit && h_hit;
            default:  tcond = 1'b0;
        endcase
    end

    // R4: a horizontal target past the last position never matches in H-only mode
    a_r4_h_limit: assert property (@(posedge clk) disable iff (rst)
        (tgt.h > HLIM && mode == TM_HONLY) |-> !tcond);

    // R5: a vertical target past the frame's last line never matches
    a_r5_v_limit: assert property (@(posedge clk) disable iff (rst)
        (tgt.v > vmax) |-> !tcond || mode == TM_HONLY);

endmodule

// File: rtl/rastirq_flags.sv
module rastirq_flags
    import rastirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tcond,
    input  logic   in_vbl,
    input  logic   rd_en,
    input  logic   rd_sel,
    input  logic   nmi_en,
    input  tmode_e mode,
    output logic   tflag,
    output logic   vflag,
    output logic   nmi,
    output logic   irq
);

    logic tcond_q;
    logic vbl_q;
    logic t_set;
    logic v_set;
    logic v_end;

    always_comb begin
        t_set = tcond && !tcond_q;
        v_set = in_vbl && !vbl_q;
        v_end = !in_vbl && vbl_q;
        irq   = tflag && (mode != TM_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcond_q <= 1'b0;
            vbl_q   <= 1'b0;
            tflag   <= 1'b0;
            vflag   <= 1'b0;
            nmi     <= 1'b0;
        end else begin
            tcond_q <= tcond;
            vbl_q   <= in_vbl;
            nmi     <= v_set && nmi_en;
            if (t_set)
                tflag <= 1'b1;
            else if (rd_en && rd_sel)
                tflag <= 1'b0;
            if (v_set)
                vflag <= 1'b1;
            else if (v_end || (rd_en && !rd_sel))
                vflag <= 1'b0;
        end
    end

    // R6: the timer flag rises only after a false-to-true edge of the condition
    a_r6_edge_only: assert property (@(posedge clk) disable iff (rst)
        $rose(tflag) |-> $past(tcond) && !$past(tcond_q));

    // R7: a status read with no coincident set leaves the timer flag clear
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel && !t_set) |=> !tflag);

    // R10: the NMI lasts one cycle and accompanies a set vblank flag
    a_r10_nmi_pulse: assert property (@(posedge clk) disable iff (rst)
        nmi |=> !nmi);
    a_r10_nmi_flag: assert property (@(posedge clk) disable iff (rst)
        nmi |-> vflag);

endmodule

// File: rtl/rastirq_top.sv
module rastirq_top
    import rastirq_pkg::*;
#(
    parameter int H_MAX          = 339,
    parameter int V_MAX_NTSC     = 261,
    parameter int V_MAX_PAL      = 311,
    parameter int VBL_START_NTSC = 225,
    parameter int VBL_START_PAL  = 240,
    parameter logic [3:0] VERSION = 4'h2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    input  logic             rd_sel,
    output logic [7:0]       rd_data,
    input  logic [CNT_W-1:0] hcount,
    input  logic [CNT_W-1:0] vcount,
    input  logic             pal_mode,
    input  logic             interlace,
    input  logic             odd_field,
    output logic             autord_en,
    output logic             irq,
    output logic             nmi
);

    ctrl_t   ctrl;
    target_t tgt;
    logic    tcond;
    logic    in_vbl;
    logic    tflag;
    logic    vflag;

    rastirq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .tgt     (tgt)
    );

    rastirq_match #(
        .H_MAX          (H_MAX),
        .V_MAX_NTSC     (V_MAX_NTSC),
        .V_MAX_PAL      (V_MAX_PAL),
        .VBL_START_NTSC (VBL_START_NTSC),
        .VBL_START_PAL  (VBL_START_PAL)
    ) u_match (
        .clk       (clk),
        .rst       (rst),
        .hcount    (hcount),
        .vcount    (vcount),
        .pal_mode  (pal_mode),
        .interlace (interlace),
        .odd_field (odd_field),
        .mode      (ctrl.mode),
        .tgt       (tgt),
        .tcond     (tcond),
        .in_vbl    (in_vbl)
    );

    rastirq_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .tcond  (tcond),
        .in_vbl (in_vbl),
        .rd_en  (rd_en),
        .rd_sel (rd_sel),
        .nmi_en (ctrl.nmi_en),
        .mode   (ctrl.mode),
        .tflag  (tflag),
        .vflag  (vflag),
        .nmi    (nmi),
        .irq    (irq)
    );

    always_comb begin
        autord_en = ctrl.autord_en;
        rd_data   = rd_sel ? {tflag, 7'b0} : {vflag, 3'b0, VERSION};
    end

    // R9: the IRQ line never stands while the timer is switched off
    a_r9_irq_mode: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl.mode != TM_OFF) && tflag);

endmodule

// File: tb/test_rastirq_top.sv
module test_rastirq_top;
    import rastirq_pkg::*;

    localparam logic [3:0] VER = 4'h2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic [8:0] hcount = 9'h1FF;
    logic [8:0] vcount = 9'h1FF;
    logic       pal_mode = 1'b0;
    logic       interlace = 1'b0;
    logic       odd_field = 1'b0;
    logic       autord_en;
    logic       irq;
    logic       nmi;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rastirq_top #(.VERSION(VER)) i_rastirq_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .hcount(hcount), .vcount(vcount), .pal_mode(pal_mode),
        .interlace(interlace), .odd_field(odd_field),
        .autord_en(autord_en), .irq(irq), .nmi(nmi)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [8:0] ht;
        logic [8:0] vt;
        logic [8:0] h;
        logic [8:0] v;
        logic       pal;
        logic       il;
        logic       odd;
        logic       exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 9'd100, 9'd0,   9'd100, 9'd10,  1'b0, 1'b0, 1'b0, 1'b1},
        '{2'd1, 9'd100, 9'd0,   9'd101, 9'd10,  1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd1, 9'd339, 9'd0,   9'd339, 9'd10,  1'b0, 1'b0, 1'b0, 1'b1},
        '{2'd1, 9'd340, 9'd0,   9'd340, 9'd10,  1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd2, 9'd0,   9'd50,  9'd0,   9'd50,  1'b0, 1'b0, 1'b0, 1'b1},
        '{2'd2, 9'd0,   9'd50,  9'd1,   9'd50,  1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd3, 9'd20,  9'd60,  9'd20,  9'd60,  1'b0, 1'b0, 1'b0, 1'b1},
        '{2'd3, 9'd20,  9'd60,  9'd20,  9'd61,  1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd0, 9'd5,   9'd0,   9'd5,   9'd0,   1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd2, 9'd0,   9'd261, 9'd0,   9'd261, 1'b0, 1'b0, 1'b0, 1'b1},
        '{2'd2, 9'd0,   9'd262, 9'd0,   9'd262, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd2, 9'd0,   9'd262, 9'd0,   9'd262, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2'd2, 9'd0,   9'd311, 9'd0,   9'd311, 1'b1, 1'b0, 1'b0, 1'b1},
        '{2'd2, 9'd0,   9'd312, 9'd0,   9'd312, 1'b1, 1'b1, 1'b0, 1'b0},
        '{2'd2, 9'd0,   9'd312, 9'd0,   9'd312, 1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd3, 9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rdclr(input logic sel);
        rd_sel = sel; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic stat(input logic sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        stat(1'b0, s); chk("R1 vblank status", {8'h0, s}, {8'h0, 4'h0, VER});
        stat(1'b1, s); chk("R1 timer status", {8'h0, s}, 16'h0);
        chk("R1 outputs", {13'h0, irq, nmi, autord_en}, 16'h0);

        // R1: upper target bit defaults to 1, so low byte 0x50 gives 0x150 (336)
        wr(3'd0, 8'h10);
        wr(3'd1, 8'h50);
        hcount = 9'd336; vcount = 9'd0;
        tick();
        stat(1'b1, s); chk("R1 default target high bit", {15'h0, s[7]}, 16'h1);
        chk("R9 irq with flag", {15'h0, irq}, 16'h1);

        // R7: read clears; R6: a held condition does not set again
        rdclr(1'b1);
        stat(1'b1, s); chk("R7 read clears timer flag", {15'h0, s[7]}, 16'h0);
        tick();
        stat(1'b1, s); chk("R6 no re-set while held", {15'h0, s[7]}, 16'h0);
        hcount = 9'd337; tick();
        hcount = 9'd336; tick();
        stat(1'b1, s); chk("R6 sets on new edge", {15'h0, s[7]}, 16'h1);

        // R7: set wins over a coincident read
        rdclr(1'b1);
        hcount = 9'd337; tick();
        hcount = 9'd336; rd_sel = 1'b1; rd_en = 1'b1; tick(); rd_en = 1'b0;
        stat(1'b1, s); chk("R7 set beats read", {15'h0, s[7]}, 16'h1);

        // R9: mode 00 drops irq but keeps the flag
        wr(3'd0, 8'h00);
        chk("R9 irq off in mode 00", {15'h0, irq}, 16'h0);
        stat(1'b1, s); chk("R9 flag kept", {15'h0, s[7]}, 16'h1);
        rdclr(1'b1);

        // R2, R3, R4, R5: table of match vectors
        for (int i = 0; i < NV; i++) begin
            hcount = 9'h1FF; vcount = 9'h1FF;
            pal_mode = VECS[i].pal; interlace = VECS[i].il; odd_field = VECS[i].odd;
            wr(3'd0, {2'b00, VECS[i].mode, 4'b0000});
            wr(3'd1, VECS[i].ht[7:0]);
            wr(3'd2, {7'b0, VECS[i].ht[8]});
            wr(3'd3, VECS[i].vt[7:0]);
            wr(3'd4, {7'b0, VECS[i].vt[8]});
            rdclr(1'b1);
            hcount = VECS[i].h; vcount = VECS[i].v;
            tick();
            stat(1'b1, s);
            chk($sformatf("R3 R4 R5 vector %0d flag", i), {15'h0, s[7]}, {15'h0, VECS[i].exp});
            chk($sformatf("R9 vector %0d irq", i), {15'h0, irq},
                {15'h0, VECS[i].exp && VECS[i].mode != 2'd0});
        end

        // R8, R10: vblank flag and NMI
        hcount = 9'd0; pal_mode = 1'b0; interlace = 1'b0; odd_field = 1'b0;
        wr(3'd0, 8'h80);
        vcount = 9'd224; tick();
        rdclr(1'b0);
        vcount = 9'd225; tick();
        stat(1'b0, s); chk("R8 vblank set on entry", {8'h0, s}, {8'h0, 1'b1, 3'b0, VER});
        chk("R10 nmi pulse", {15'h0, nmi}, 16'h1);
        tick();
        chk("R10 nmi one cycle", {15'h0, nmi}, 16'h0);
        rdclr(1'b0);
        stat(1'b0, s); chk("R7 read clears vblank", {15'h0, s[7]}, 16'h0);
        vcount = 9'd226; tick();
        stat(1'b0, s); chk("R8 no re-set inside vblank", {15'h0, s[7]}, 16'h0);
        vcount = 9'd224; tick();
        vcount = 9'd225; tick();
        vcount = 9'd0; tick();
        stat(1'b0, s); chk("R8 cleared at vblank end", {15'h0, s[7]}, 16'h0);

        // R10: NMI disabled still sets flag
        wr(3'd0, 8'h01);
        chk("R2 autoread bit", {15'h0, autord_en}, 16'h1);
        vcount = 9'd224; tick();
        vcount = 9'd225; tick();
        stat(1'b0, s); chk("R8 flag without nmi enable", {15'h0, s[7]}, 16'h1);
        chk("R10 nmi masked", {15'h0, nmi}, 16'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule